// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two 32-bit binary32 operands and produces their correctly rounded sum together with four exception flags. Each operand is first sorted into one of six classes: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. Pairs that involve a NaN, an infinity or a zero are settled by a fixed priority and never reach the arithmetic path. The arithmetic path handles two finite nonzero operands. Subnormals are normalised internally. The significands are extended with guard, round and sticky positions and aligned to the larger exponent. They are then added or subtracted, renormalised, and rounded under a two-bit mode input.

The datapath is combinational from the operand ports to one output register stage. A sum appears on the outputs on the clock edge that follows the cycle in which its operands and mode were presented, and a new pair can be applied every cycle. Subtraction is done by the caller, who flips the sign bit of the second operand. There are no trap outputs and no flush-to-zero mode.

Top module: `fpadd_sp`

## Requirements
- R1: If either operand is a signalling NaN (exponent all ones, fraction nonzero, fraction MSB bit 22 clear), the result is the default NaN 0x7FC00000 and only the invalid flag is set, whatever the other operand is.
- R2: With no signalling NaN present, a quiet NaN (fraction bit 22 set) in operand A is returned bit for bit. Otherwise a quiet NaN in operand B is returned bit for bit. No flag is raised.
- R3: Two infinities of the same sign give that infinity with no flags. Opposite signs give 0x7FC00000 with the invalid flag.
- R4: An infinity added to a zero or finite value returns the infinity operand unchanged, with no flags.
- R5: Two zeros of equal sign return that zero. Opposite-signed zeros give +0, except under mode 2'b11, where they give -0 (0x80000000). No flags are raised.
- R6: A zero added to a nonzero finite operand (normal or subnormal) returns the nonzero operand unchanged, with no flags.
- R7: A finite sum that is exactly representable is returned exactly with no flags. This holds for normal and subnormal operands and for subtraction that needs a left shift.
- R8: Nonzero operands that cancel exactly give +0, or -0 under mode 2'b11, with no flags.
- R9: The mode input selects 2'b00 nearest with ties to even, 2'b01 toward zero, 2'b10 toward +infinity and 2'b11 toward -infinity. The inexact flag is set whenever any guard, round or sticky bit is nonzero.
- R10: A carry out of rounding renormalises the result. For example, 1.0 + (-2^-25) under nearest gives exactly 0x3F800000 with the inexact flag.
- R11: On exponent overflow after rounding, both overflow and inexact are set. The result is infinity under nearest, under +infinity for a positive sum and under -infinity for a negative sum. In every other case it is the largest finite value of the result's sign.
- R12: A result below the normal range is delivered as a subnormal. Underflow is set only when such a tiny result is also inexact, so an exact tiny sum raises no flags.
- R13: The result and flags are registered: they appear after the first rising clock edge that follows the inputs. A synchronous active-high reset clears the result and all flags to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | 32 | First addend, binary32 |
| op_b | input | 32 | Second addend, binary32 |
| rnd_mode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 up, 11 down |
| sum | output | 32 | Registered sum, binary32 |
| flg_invalid | output | 1 | Invalid-operation flag for the registered sum |
| flg_overflow | output | 1 | Overflow flag for the registered sum |
| flg_underflow | output | 1 | Underflow flag for the registered sum |
| flg_inexact | output | 1 | Inexact flag for the registered sum |

## Verification
The clocked checks assume that op_a, op_b and rnd_mode are known values on every edge once reset has been released. The operand-passing checks also compare against the operands one edge earlier, so they assume that every input value is meant to be consumed. The stimulus follows both rules. Every input is driven on a falling edge and held through the next rising edge. No pair is left undefined, and each result is sampled one time unit after the edge that registers it.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int EXT_W  = SIG_W + 3;
    localparam int SEXP_W = EXP_W + 2;

    localparam logic [EXP_W-1:0]         EXP_ONES = '1;
    localparam logic signed [SEXP_W-1:0] EXP_LIM  = $signed({2'b00, EXP_ONES});
    localparam logic signed [SEXP_W-1:0] SEXP_ONE = 1;
    localparam logic [WORD_W-1:0] DEFAULT_NAN =
        {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef enum logic [2:0] {
        CL_ZERO, CL_SUB, CL_NORM, CL_INF, CL_QNAN, CL_SNAN
    } fp_class_e;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_UP      = 2'b10,
        RM_DOWN    = 2'b11
    } rnd_mode_e;

    typedef struct packed {
        logic                     sign;
        logic signed [SEXP_W-1:0] exp;
        logic [SIG_W-1:0]         sig;
    } unpacked_t;

    typedef struct packed {
        logic                     sign;
        logic signed [SEXP_W-1:0] exp;
        logic [EXT_W-1:0]         mag;
        logic                     zero;
    } raw_sum_t;

    typedef struct packed {
        logic invalid;
        logic overflow;
        logic underflow;
        logic inexact;
    } fp_flags_t;

    function automatic fp_class_e classify(logic [WORD_W-1:0] w);
        logic [EXP_W-1:0]  e;
        logic [FRAC_W-1:0] f;
        e = w[WORD_W-2 -: EXP_W];
        f = w[FRAC_W-1:0];
        if (e == '0)
            return (f == '0) ? CL_ZERO : CL_SUB;
        if (e == EXP_ONES) begin
            if (f == '0)
                return CL_INF;
            return f[FRAC_W-1] ? CL_QNAN : CL_SNAN;
        end
        return CL_NORM;
    endfunction

    function automatic int lead_zeros(logic [EXT_W-1:0] v);
        int n;
        n = EXT_W;
        for (int i = 0; i < EXT_W; i++)
            if (v[i]) n = EXT_W - 1 - i;
        return n;
    endfunction

    function automatic logic [EXT_W-1:0] shr_sticky(logic [EXT_W-1:0] m, int amt);
        logic [EXT_W-1:0] lost;
        logic [EXT_W-1:0] kept;
        if (amt <= 0)
            return m;
        if (amt >= EXT_W)
            return {{(EXT_W-1){1'b0}}, |m};
        lost    = m & ~({EXT_W{1'b1}} << amt);
        kept    = m >> amt;
        kept[0] = kept[0] | (|lost);
        return kept;
    endfunction

    function automatic logic [WORD_W-1:0] cancel_zero(rnd_mode_e m);
        return {(m == RM_DOWN), {(WORD_W-1){1'b0}}};
    endfunction

endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack
    import fpadd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fp_class_e         cls,
    output unpacked_t         opnd
);
    logic [EXP_W-1:0]  efield;
    logic [FRAC_W-1:0] ffield;
    int                lz;

    assign efield = word[WORD_W-2 -: EXP_W];
    assign ffield = word[FRAC_W-1:0];
    assign cls    = classify(word);

    always_comb begin
        opnd.sign = word[WORD_W-1];
        lz        = lead_zeros({1'b0, ffield, 3'b000});
        if (cls == CL_SUB) begin
            // shift the first set bit up into the hidden position
            opnd.sig = {1'b0, ffield} << lz;
            opnd.exp = SEXP_ONE - SEXP_W'(lz);
        end else begin
            opnd.sig = {(efield != '0), ffield};
            opnd.exp = $signed({2'b00, efield});
        end
    end
endmodule

// File: rtl/fpadd_align_add.sv
module fpadd_align_add
    import fpadd_pkg::*;
(
    input  unpacked_t a,
    input  unpacked_t b,
    output raw_sum_t  res
);
    logic signed [SEXP_W-1:0] ediff;
    logic signed [SEXP_W-1:0] ebig;
    logic [EXT_W-1:0]         ma;
    logic [EXT_W-1:0]         mb;
    logic [EXT_W:0]           total;
    logic [EXT_W-1:0]         delta;
    int                       lz;

    always_comb begin
        ediff = a.exp - b.exp;
        if (ediff >= 0) begin
            ebig = a.exp;
            ma   = {a.sig, 3'b000};
            mb   = shr_sticky({b.sig, 3'b000}, int'(ediff));
        end else begin
            ebig = b.exp;
            ma   = shr_sticky({a.sig, 3'b000}, int'(-ediff));
            mb   = {b.sig, 3'b000};
        end

        total    = '0;
        delta    = '0;
        lz       = 0;
        res.zero = 1'b0;
        if (a.sign == b.sign) begin
            total    = {1'b0, ma} + {1'b0, mb};
            res.sign = a.sign;
            if (total[EXT_W]) begin
                res.mag = {total[EXT_W:2], total[1] | total[0]};
                res.exp = ebig + SEXP_ONE;
            end else begin
                res.mag = total[EXT_W-1:0];
                res.exp = ebig;
            end
        end else begin
            if (ma >= mb) begin
                delta    = ma - mb;
                res.sign = a.sign;
            end else begin
                delta    = mb - ma;
                res.sign = b.sign;
            end
            res.zero = (delta == '0);
            lz       = lead_zeros(delta);
            res.mag  = delta << lz;
            res.exp  = ebig - SEXP_W'(lz);
        end
    end
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
    import fpadd_pkg::*;
(
    input  raw_sum_t          raw,
    input  rnd_mode_e         mode,
    output logic [WORD_W-1:0] word,
    output fp_flags_t         flags
);
    logic                     tiny;
    logic [EXT_W-1:0]         m;
    logic signed [SEXP_W-1:0] e_pre;
    logic signed [SEXP_W-1:0] e_post;
    logic                     lsb, grd, rnd, stk, inx, bump;
    logic [SIG_W:0]           rsig;
    logic                     hidden;
    logic                     to_inf;

    always_comb begin
        tiny = (raw.exp < SEXP_ONE);
        if (tiny) begin
            m     = shr_sticky(raw.mag, int'(SEXP_ONE - raw.exp));
            e_pre = SEXP_ONE;
        end else begin
            m     = raw.mag;
            e_pre = raw.exp;
        end

        lsb = m[3];
        grd = m[2];
        rnd = m[1];
        stk = m[0];
        inx = grd | rnd | stk;

        unique case (mode)
            RM_NEAREST: bump = grd & (rnd | stk | lsb);
            RM_ZERO:    bump = 1'b0;
            RM_UP:      bump = inx & ~raw.sign;
            RM_DOWN:    bump = inx & raw.sign;
            default:    bump = 1'b0;
        endcase

        rsig   = {1'b0, m[EXT_W-1:3]} + {{SIG_W{1'b0}}, bump};
        hidden = rsig[SIG_W] | rsig[SIG_W-1];
        e_post = rsig[SIG_W] ? e_pre + SEXP_ONE : e_pre;
        to_inf = (mode == RM_NEAREST) || (mode == RM_UP && !raw.sign)
                 || (mode == RM_DOWN && raw.sign);

        flags = '0;
        if (raw.zero) begin
            word = cancel_zero(mode);
        end else if (e_post >= EXP_LIM) begin
            flags.overflow = 1'b1;
            flags.inexact  = 1'b1;
            word = to_inf ? {raw.sign, EXP_ONES, {FRAC_W{1'b0}}}
                          : {raw.sign, EXP_ONES - 1'b1, {FRAC_W{1'b1}}};
        end else begin
            flags.inexact   = inx;
            flags.underflow = tiny & inx;
            word = {raw.sign,
                    hidden ? e_post[EXP_W-1:0] : {EXP_W{1'b0}},
                    rsig[SIG_W] ? {FRAC_W{1'b0}} : rsig[FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/fpadd_sp.sv
module fpadd_sp
    import fpadd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [1:0]        rnd_mode,
    output logic [WORD_W-1:0] sum,
    output logic              flg_invalid,
    output logic              flg_overflow,
    output logic              flg_underflow,
    output logic              flg_inexact
);
    fp_class_e         cls_a, cls_b;
    unpacked_t         un_a, un_b;
    raw_sum_t          raw;
    rnd_mode_e         mode;
    logic [WORD_W-1:0] arith_word;
    fp_flags_t         arith_flags;
    logic [WORD_W-1:0] res_d;
    fp_flags_t         flg_d;
    logic              sign_a, sign_b;

    assign mode   = rnd_mode_e'(rnd_mode);
    assign sign_a = op_a[WORD_W-1];
    assign sign_b = op_b[WORD_W-1];

    fpadd_unpack u_unp_a (.word(op_a), .cls(cls_a), .opnd(un_a));
    fpadd_unpack u_unp_b (.word(op_b), .cls(cls_b), .opnd(un_b));
    fpadd_align_add u_add (.a(un_a), .b(un_b), .res(raw));
    fpadd_round u_rnd (.raw(raw), .mode(mode), .word(arith_word), .flags(arith_flags));

    // fixed special-pair priority
    always_comb begin
        res_d = arith_word;
        flg_d = arith_flags;
        if (cls_a == CL_SNAN || cls_b == CL_SNAN) begin
            res_d = DEFAULT_NAN;
            flg_d = '{invalid: 1'b1, default: 1'b0};
        end else if (cls_a == CL_QNAN) begin
            res_d = op_a;
            flg_d = '0;
        end else if (cls_b == CL_QNAN) begin
            res_d = op_b;
            flg_d = '0;
        end else if (cls_a == CL_INF && cls_b == CL_INF) begin
            if (sign_a == sign_b) begin
                res_d = op_a;
                flg_d = '0;
            end else begin
                res_d = DEFAULT_NAN;
                flg_d = '{invalid: 1'b1, default: 1'b0};
            end
        end else if (cls_a == CL_INF) begin
            res_d = op_a;
            flg_d = '0;
        end else if (cls_b == CL_INF) begin
            res_d = op_b;
            flg_d = '0;
        end else if (cls_a == CL_ZERO && cls_b == CL_ZERO) begin
            res_d = (sign_a == sign_b) ? op_a : cancel_zero(mode);
            flg_d = '0;
        end else if (cls_a == CL_ZERO) begin
            res_d = op_b;
            flg_d = '0;
        end else if (cls_b == CL_ZERO) begin
            res_d = op_a;
            flg_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum           <= '0;
            flg_invalid   <= 1'b0;
            flg_overflow  <= 1'b0;
            flg_underflow <= 1'b0;
            flg_inexact   <= 1'b0;
        end else begin
            sum           <= res_d;
            flg_invalid   <= flg_d.invalid;
            flg_overflow  <= flg_d.overflow;
            flg_underflow <= flg_d.underflow;
            flg_inexact   <= flg_d.inexact;
        end
    end

    AST_INVALID_NAN: assert property (@(posedge clk) disable iff (rst)
        flg_invalid |-> (sum == DEFAULT_NAN && !flg_overflow && !flg_inexact)); // R1
    AST_QNAN_A_PASS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cls_a == CL_QNAN && cls_b != CL_SNAN))
        |-> (sum == $past(op_a) && !flg_invalid)); // R2
    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cls_a == CL_ZERO && (cls_b == CL_NORM || cls_b == CL_SUB)))
        |-> (sum == $past(op_b) && !flg_inexact)); // R6
    AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (rst)
        flg_overflow |-> flg_inexact); // R11
    AST_UNF_INEXACT: assert property (@(posedge clk) disable iff (rst)
        flg_underflow |-> flg_inexact); // R12
    AST_FLAGS_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (sum == '0 && !flg_invalid && !flg_inexact)); // R13
endmodule

// File: tb/sim_fpadd_sp.sv
`timescale 1ns/100ps
module sim_fpadd_sp;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [1:0]  rnd_mode = 2'b00;
    logic [31:0] sum;
    logic        flg_invalid, flg_overflow, flg_underflow, flg_inexact;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fpadd_sp u0 (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .rnd_mode(rnd_mode),
        .sum(sum), .flg_invalid(flg_invalid), .flg_overflow(flg_overflow),
        .flg_underflow(flg_underflow), .flg_inexact(flg_inexact)
    );

    // flags packed as {invalid, overflow, underflow, inexact}
    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic [1:0] m, input logic [31:0] want,
                         input logic [3:0] want_f, input string req);
        logic [3:0] got_f;
        @(negedge clk);
        op_a = a; op_b = b; rnd_mode = m;
        @(posedge clk);
        #1;
        got_f = {flg_invalid, flg_overflow, flg_underflow, flg_inexact};
        n_checks++;
        if (sum !== want || got_f !== want_f) begin
            n_fails++;
            $display("FAIL %s: a=%h b=%h mode=%b got %h/%b expected %h/%b",
                     req, a, b, m, sum, got_f, want, want_f);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1; op_a = 32'h3F800000; op_b = 32'h3F800000;
        @(posedge clk);
        #1;
        n_checks++;
        if (sum !== 32'h0 || {flg_invalid, flg_overflow, flg_underflow, flg_inexact} !== 4'b0) begin
            n_fails++;
            $display("FAIL R13: reset state got %h expected 00000000", sum);
        end
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_nans;
        apply(32'h7F800001, 32'h7FC00005, 2'b00, 32'h7FC00000, 4'b1000, "R1");
        apply(32'h3F800000, 32'hFF800002, 2'b00, 32'h7FC00000, 4'b1000, "R1");
        apply(32'hFFC00001, 32'h7FC00002, 2'b00, 32'hFFC00001, 4'b0000, "R2");
        apply(32'h3F800000, 32'h7FC00003, 2'b01, 32'h7FC00003, 4'b0000, "R2");
    endtask

    task automatic t_infinities;
        apply(32'h7F800000, 32'h7F800000, 2'b00, 32'h7F800000, 4'b0000, "R3");
        apply(32'h7F800000, 32'hFF800000, 2'b00, 32'h7FC00000, 4'b1000, "R3");
        apply(32'h3F800000, 32'hFF800000, 2'b00, 32'hFF800000, 4'b0000, "R4");
        apply(32'h7F800000, 32'h80000000, 2'b11, 32'h7F800000, 4'b0000, "R4");
    endtask

    task automatic t_zeros;
        apply(32'h80000000, 32'h80000000, 2'b00, 32'h80000000, 4'b0000, "R5");
        apply(32'h00000000, 32'h80000000, 2'b00, 32'h00000000, 4'b0000, "R5");
        apply(32'h00000000, 32'h80000000, 2'b11, 32'h80000000, 4'b0000, "R5");
        apply(32'h80000000, 32'h00000003, 2'b00, 32'h00000003, 4'b0000, "R6");
        apply(32'hC0000000, 32'h00000000, 2'b10, 32'hC0000000, 4'b0000, "R6");
    endtask

    task automatic t_exact;
        apply(32'h3F800000, 32'h40000000, 2'b00, 32'h40400000, 4'b0000, "R7");
        apply(32'h3F800000, 32'hBF7FFFFF, 2'b00, 32'h33800000, 4'b0000, "R7");
        apply(32'h3F800000, 32'hB3800000, 2'b01, 32'h3F7FFFFF, 4'b0000, "R7");
        apply(32'h3F800000, 32'hBF800000, 2'b00, 32'h00000000, 4'b0000, "R8");
        apply(32'h3F800000, 32'hBF800000, 2'b11, 32'h80000000, 4'b0000, "R8");
    endtask

    task automatic t_rounding;
        apply(32'h3F800000, 32'h33800000, 2'b00, 32'h3F800000, 4'b0001, "R9");
        apply(32'h3F800001, 32'h33800000, 2'b00, 32'h3F800002, 4'b0001, "R9");
        apply(32'h3F800000, 32'h33800000, 2'b10, 32'h3F800001, 4'b0001, "R9");
        apply(32'hBF800000, 32'hB3800000, 2'b11, 32'hBF800001, 4'b0001, "R9");
        apply(32'hBF800000, 32'hB3800000, 2'b10, 32'hBF800000, 4'b0001, "R9");
        apply(32'h3F800000, 32'hB3000000, 2'b00, 32'h3F800000, 4'b0001, "R10");
        apply(32'h3F800000, 32'hB3000000, 2'b01, 32'h3F7FFFFF, 4'b0001, "R10");
    endtask

    task automatic t_overflow;
        apply(32'h7F7FFFFF, 32'h7F7FFFFF, 2'b00, 32'h7F800000, 4'b0101, "R11");
        apply(32'h7F7FFFFF, 32'h7F7FFFFF, 2'b01, 32'h7F7FFFFF, 4'b0101, "R11");
        apply(32'hFF7FFFFF, 32'hFF7FFFFF, 2'b10, 32'hFF7FFFFF, 4'b0101, "R11");
        apply(32'hFF7FFFFF, 32'hFF7FFFFF, 2'b11, 32'hFF800000, 4'b0101, "R11");
    endtask

    task automatic t_tiny;
        apply(32'h00000001, 32'h00000001, 2'b00, 32'h00000002, 4'b0000, "R12");
        apply(32'h00800000, 32'h80000001, 2'b00, 32'h007FFFFF, 4'b0000, "R12");
        apply(32'h007FFFFF, 32'h00000001, 2'b00, 32'h00800000, 4'b0000, "R12");
    endtask

    task automatic t_latency;
        // R13: a new pair every cycle, each result one edge later
        apply(32'h40000000, 32'h40000000, 2'b00, 32'h40800000, 4'b0000, "R13");
        apply(32'h3F800000, 32'h3F800000, 2'b00, 32'h40000000, 4'b0000, "R13");
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        t_reset();
        t_nans();
        t_infinities();
        t_zeros();
        t_exact();
        t_rounding();
        t_overflow();
        t_tiny();
        t_latency();
        finished = 1'b1;
        report();
    end

    initial begin
        for (int cyc = 0; cyc < 5000; cyc++) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            report();
        end
    end
endmodule